// File: doc/BRIEF.md
# Serial-Bus Time and Split-Timeout Control Registers

This block holds the time-keeping control registers of a serial-bus node. A link layer keeps a free-running 32-bit cycle-time counter and presents a sampled copy of it on every cycle. The block turns that sample into a bus-time register with seconds resolution. It never watches the counter continuously. Instead, each read of cycle time or bus time compares the fresh sample with the last one recorded. When the fresh sample is smaller, the counter has rolled over, so the stored seconds are advanced by 128.

The block also holds the split-transaction timeout. This is a whole-seconds field plus a field counted in 125 microsecond units. The block converts the pair into a microsecond value with a floor of 100 ms, then divides that value by a configurable tick period. The result feeds an external transaction-expiry timer.

Accesses arrive as single quadlet reads or writes addressed by byte offset. Each access is answered one cycle later with a response code and read data. A write to cycle time is forwarded to the link as a one-cycle load request.

Top module: `sbus_time_csr`

## Requirements
- R1: After reset, the timeout seconds field reads 0, the timeout fraction register reads 0x19000000 (800 units in bits 31:19), the recorded cycle sample and the stored bus-time seconds are 0, and `expiry_ticks` equals 100000 / TICK_US.
- R2: Every cycle with `req_valid` high is answered on the next cycle with `rsp_valid` high, and `rsp_valid` is low otherwise. `rsp_code` is 0 for complete, 1 for type error and 2 for address error. `rsp_rdata` is 0 except on a complete read.
- R3: The byte offsets are 0x0 timeout seconds, 0x4 timeout fraction, 0x8 cycle time and 0xC bus time. An offset with bits 1:0 nonzero gets a type error. Any other aligned offset gets an address error. Neither kind of error changes any state.
- R4: A write to the timeout seconds register keeps only wdata bits 2:0, which read back in bits 2:0. A write to the fraction register keeps only bits 31:19, which read back in place with bits 18:0 zero.
- R5: A cycle-time read returns `cyc_sample`. If `cyc_sample` is less than the recorded sample, the stored seconds (bits 31:7) increase by 128, modulo 2^32. The recorded sample then becomes `cyc_sample`.
- R6: A bus-time read first applies the same rollover update as R5. It then returns the stored bits 31:7 with `cyc_sample[31:25]` in bits 6:0.
- R7: A write to bus time stores wdata bits 31:7 and discards bits 6:0.
- R8: A write to cycle time raises `cyc_load_valid` for exactly the following cycle, with `cyc_load_data` equal to wdata. It also makes wdata the recorded sample for later rollover comparisons.
- R9: The effective timeout is max(sec × 1,000,000 + units × 125, 100,000) microseconds. Within USEC_W+3 cycles of a timeout write, `expiry_ticks` equals that value divided by TICK_US, rounded down. `expiry_ticks` is never below 100000 / TICK_US.
- R10: A timeout write that lands while an earlier conversion is still running restarts the conversion. `expiry_ticks` settles to the value of the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_offset | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| cyc_sample | input | 32 | Sampled cycle-time counter from the link |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| rsp_rdata | output | 32 | Read data |
| cyc_load_valid | output | 1 | One-cycle request to load the link counter |
| cyc_load_data | output | 32 | Value to load into the link counter |
| expiry_ticks | output | TICK_W | Timeout expressed in timer ticks |

## Verification
Two functions can collide in the same cycle. The first is the tick conversion finishing. The second is a fresh timeout write, which must restart that conversion and suppress the stale result.

The bench provokes the collision by issuing a series of timeout writes. The gaps between them are swept across the conversion length, so one write lands exactly on the finishing cycle, one just before it and one just after it. After the last write the bench waits out the conversion. It then judges `expiry_ticks` against the value computed from the last write alone.

A second overlap comes from a rollover detected during a bus-time read. That read must both advance the seconds and return them in the same response. The bench checks this with a rollover sample whose top bits are nonzero.

// File: rtl/sbus_time_pkg.sv
`timescale 1ns/1ps
package sbus_time_pkg;

    localparam int unsigned USEC_PER_SEC   = 1000000;
    localparam int unsigned USEC_PER_UNIT  = 125;
    localparam int unsigned MIN_USEC       = 100000;
    localparam int unsigned FRAC_RESET     = 800;
    localparam int          SEC_W          = 3;
    localparam int          FRAC_W         = 13;
    localparam int          FRAC_LSB       = 19;
    localparam int          SECS_W         = 25;
    localparam int          SECS_LSB       = 7;

    typedef enum logic [1:0] {
        RSP_OK       = 2'd0,
        RSP_TYPE_ERR = 2'd1,
        RSP_ADDR_ERR = 2'd2
    } rsp_code_e;

    typedef enum logic [2:0] {
        SEL_TO_SEC,
        SEL_TO_FRAC,
        SEL_CYCLE,
        SEL_BUSTIME,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     misaligned;
    } decode_t;

    typedef struct packed {
        logic             wr_sec;
        logic             wr_frac;
        logic             wr_cycle;
        logic             wr_bus;
        logic             rd_time;
        rsp_code_e        code;
        logic [31:0]      rdata;
    } action_t;

    // Clamped timeout in microseconds for a seconds / fraction pair
    function automatic logic [31:0] timeout_usec(input logic [SEC_W-1:0]  sec,
                                                 input logic [FRAC_W-1:0] frac);
        logic [31:0] raw;
        raw = 32'(sec) * 32'(USEC_PER_SEC) + 32'(frac) * 32'(USEC_PER_UNIT);
        return (raw < 32'(MIN_USEC)) ? 32'(MIN_USEC) : raw;
    endfunction

    // Tick count that applies straight out of reset
    function automatic int unsigned reset_ticks(input int unsigned tick_us);
        int unsigned us;
        us = FRAC_RESET * USEC_PER_UNIT;
        if (us < MIN_USEC) us = MIN_USEC;
        return us / tick_us;
    endfunction

endpackage

// File: rtl/sbus_time_decode.sv
`timescale 1ns/1ps
module sbus_time_decode
    import sbus_time_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] offset,
    output decode_t           dec
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;

    always_comb begin
        word_idx       = offset[ADDR_W-1:2];
        dec.misaligned = (offset[1:0] != 2'b00);
        case (word_idx)
            IDX_W'(0): dec.sel = SEL_TO_SEC;
            IDX_W'(1): dec.sel = SEL_TO_FRAC;
            IDX_W'(2): dec.sel = SEL_CYCLE;
            IDX_W'(3): dec.sel = SEL_BUSTIME;
            default:   dec.sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/sbus_time_bustime.sv
`timescale 1ns/1ps
module sbus_time_bustime
    import sbus_time_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_time,
    input  logic        wr_cycle,
    input  logic        wr_bus,
    input  logic [31:0] wdata,
    input  logic [31:0] sample,
    output logic [31:0] cycle_rdata,
    output logic [31:0] bus_rdata
);
    logic [31:0]       last_sample;
    logic [SECS_W-1:0] secs_q;
    logic [SECS_W-1:0] secs_adv;
    logic              rolled;

    always_comb begin
        rolled      = (sample < last_sample);
        secs_adv    = secs_q + SECS_W'(rolled);
        cycle_rdata = sample;
        bus_rdata   = {secs_adv, sample[31:32-SECS_LSB]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_sample <= '0;
            secs_q      <= '0;
        end else if (wr_cycle) begin
            last_sample <= wdata;
        end else if (wr_bus) begin
            secs_q      <= wdata[31:SECS_LSB];
        end else if (rd_time) begin
            last_sample <= sample;
            secs_q      <= secs_adv;
        end
    end
endmodule

// File: rtl/sbus_time_timeout.sv
`timescale 1ns/1ps
module sbus_time_timeout
    import sbus_time_pkg::*;
#(
    parameter int USEC_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sec,
    input  logic              wr_frac,
    input  logic [31:0]       wdata,
    output logic [31:0]       sec_rdata,
    output logic [31:0]       frac_rdata,
    output logic [USEC_W-1:0] usec,
    output logic              changed
);
    logic [SEC_W-1:0]  sec_q;
    logic [FRAC_W-1:0] frac_q;
    logic [31:0]       usec_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q   <= '0;
            frac_q  <= FRAC_W'(FRAC_RESET);
            changed <= 1'b0;
        end else begin
            if (wr_sec)  sec_q  <= wdata[SEC_W-1:0];
            if (wr_frac) frac_q <= wdata[31:FRAC_LSB];
            changed <= wr_sec | wr_frac;
        end
    end

    always_comb begin
        sec_rdata  = {{(32-SEC_W){1'b0}}, sec_q};
        frac_rdata = {frac_q, {FRAC_LSB{1'b0}}};
        usec_full  = timeout_usec(sec_q, frac_q);
        usec       = usec_full[USEC_W-1:0];
    end
endmodule

// File: rtl/sbus_time_div.sv
`timescale 1ns/1ps
module sbus_time_div #(
    parameter int          W        = 24,
    parameter int unsigned DIVISOR  = 1000,
    parameter int unsigned RESET_Q  = 100
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    output logic [W-1:0] quotient
);
    localparam int         CNT_W   = $clog2(W + 1);
    localparam logic [W:0] DIV_EXT = (W+1)'(DIVISOR);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     rem;
    logic [W-1:0]     quo;
    logic [W:0]       shifted;
    logic [W:0]       diff;
    logic             fits;
    logic [W-1:0]     rem_nxt;
    logic [W-1:0]     quo_nxt;

    always_comb begin
        shifted = {rem, quo[W-1]};
        diff    = shifted - DIV_EXT;
        fits    = (shifted >= DIV_EXT);
        rem_nxt = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_nxt = {quo[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            rem      <= '0;
            quo      <= '0;
            quotient <= W'(RESET_Q);
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(W);
            rem  <= '0;
            quo  <= dividend;
        end else if (busy) begin
            rem <= rem_nxt;
            quo <= quo_nxt;
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
                busy     <= 1'b0;
                quotient <= quo_nxt;
            end
        end
    end
endmodule

// File: rtl/sbus_time_csr.sv
`timescale 1ns/1ps
module sbus_time_csr
    import sbus_time_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter int unsigned TICK_US = 1000,
    parameter int          USEC_W  = 24,
    parameter int          TICK_W  = USEC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       cyc_sample,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [31:0]       rsp_rdata,
    output logic              cyc_load_valid,
    output logic [31:0]       cyc_load_data,
    output logic [TICK_W-1:0] expiry_ticks
);
    localparam int unsigned INIT_TICKS = reset_ticks(TICK_US);

    decode_t           dec;
    action_t           act;
    logic [31:0]       sec_rdata;
    logic [31:0]       frac_rdata;
    logic [31:0]       cycle_rdata;
    logic [31:0]       bus_rdata;
    logic [USEC_W-1:0] usec;
    logic              to_changed;
    logic [USEC_W-1:0] ticks_full;

    sbus_time_decode #(.ADDR_W(ADDR_W)) u_decode (
        .offset (req_offset),
        .dec    (dec)
    );

    always_comb begin
        act = '{wr_sec: 1'b0, wr_frac: 1'b0, wr_cycle: 1'b0, wr_bus: 1'b0,
                rd_time: 1'b0, code: RSP_OK, rdata: 32'd0};
        if (req_valid) begin
            if (dec.misaligned) begin
                act.code = RSP_TYPE_ERR;
            end else begin
                case (dec.sel)
                    SEL_TO_SEC: begin
                        act.wr_sec = req_write;
                        act.rdata  = sec_rdata;
                    end
                    SEL_TO_FRAC: begin
                        act.wr_frac = req_write;
                        act.rdata   = frac_rdata;
                    end
                    SEL_CYCLE: begin
                        act.wr_cycle = req_write;
                        act.rd_time  = !req_write;
                        act.rdata    = cycle_rdata;
                    end
                    SEL_BUSTIME: begin
                        act.wr_bus  = req_write;
                        act.rd_time = !req_write;
                        act.rdata   = bus_rdata;
                    end
                    default: act.code = RSP_ADDR_ERR;
                endcase
            end
            if (req_write || act.code != RSP_OK) act.rdata = 32'd0;
        end
    end

    sbus_time_bustime u_bustime (
        .clk         (clk),
        .rst         (rst),
        .rd_time     (act.rd_time),
        .wr_cycle    (act.wr_cycle),
        .wr_bus      (act.wr_bus),
        .wdata       (req_wdata),
        .sample      (cyc_sample),
        .cycle_rdata (cycle_rdata),
        .bus_rdata   (bus_rdata)
    );

    sbus_time_timeout #(.USEC_W(USEC_W)) u_timeout (
        .clk        (clk),
        .rst        (rst),
        .wr_sec     (act.wr_sec),
        .wr_frac    (act.wr_frac),
        .wdata      (req_wdata),
        .sec_rdata  (sec_rdata),
        .frac_rdata (frac_rdata),
        .usec       (usec),
        .changed    (to_changed)
    );

    sbus_time_div #(
        .W       (USEC_W),
        .DIVISOR (TICK_US),
        .RESET_Q (INIT_TICKS)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (to_changed),
        .dividend (usec),
        .quotient (ticks_full)
    );

    generate
        if (TICK_W >= USEC_W) begin : g_wide
            assign expiry_ticks = TICK_W'(ticks_full);
        end else begin : g_narrow
            assign expiry_ticks = ticks_full[TICK_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_code       <= RSP_OK;
            rsp_rdata      <= '0;
            cyc_load_valid <= 1'b0;
            cyc_load_data  <= '0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_code       <= act.code;
            rsp_rdata      <= act.rdata;
            cyc_load_valid <= act.wr_cycle;
            cyc_load_data  <= act.wr_cycle ? req_wdata : cyc_load_data;
        end
    end
endmodule

// File: rtl/sbus_time_csr_chk.sv
`timescale 1ns/1ps
module sbus_time_csr_chk #(
    parameter int          ADDR_W  = 8,
    parameter int unsigned TICK_US = 1000,
    parameter int          TICK_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_offset,
    input logic [31:0]       req_wdata,
    input logic [31:0]       cyc_sample,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic [31:0]       rsp_rdata,
    input logic              cyc_load_valid,
    input logic [31:0]       cyc_load_data,
    input logic [TICK_W-1:0] expiry_ticks
);
    localparam logic [TICK_W-1:0] MIN_TICKS = TICK_W'(100000 / TICK_US);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2
    err_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 2'd0) |-> (rsp_rdata == 32'd0));

    // R3
    misaligned_type_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_offset[1:0] != 2'b00) |=> (rsp_code == 2'd1));

    // R5
    cycle_read_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_offset == ADDR_W'(8))
        |=> (rsp_rdata == $past(cyc_sample)));

    // R6
    bus_read_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_offset == ADDR_W'(12))
        |=> (rsp_rdata[6:0] == $past(cyc_sample[31:25])));

    // R8
    cyc_load_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_offset == ADDR_W'(8))
        |=> (cyc_load_valid && cyc_load_data == $past(req_wdata)));

    // R8
    cyc_load_single_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_offset == ADDR_W'(8)) |=> !cyc_load_valid);

    // R9
    expiry_floor_chk: assert property (@(posedge clk) disable iff (rst)
        expiry_ticks >= MIN_TICKS);
endmodule

bind sbus_time_csr sbus_time_csr_chk #(
    .ADDR_W  (ADDR_W),
    .TICK_US (TICK_US),
    .TICK_W  (TICK_W)
) u_chk (.*);

// File: tb/sbus_time_csr_test.sv
`timescale 1ns/1ps
module sbus_time_csr_test;
    localparam int          ADDR_W  = 8;
    localparam int unsigned TICK_US = 1000;
    localparam int          TICK_W  = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_offset = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       cyc_sample = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_code;
    logic [31:0]       rsp_rdata;
    logic              cyc_load_valid;
    logic [31:0]       cyc_load_data;
    logic [TICK_W-1:0] expiry_ticks;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0]  code;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // bench model of the register state
    longint m_sec  = 0;
    longint m_frac = 800;

    always #2.5 clk = ~clk;

    sbus_time_csr #(.ADDR_W(ADDR_W), .TICK_US(TICK_US), .TICK_W(TICK_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_wdata(req_wdata), .cyc_sample(cyc_sample),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .cyc_load_valid(cyc_load_valid), .cyc_load_data(cyc_load_data),
        .expiry_ticks(expiry_ticks)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic longint model_ticks(input longint sec, input longint frac);
        longint us;
        us = sec * 1000000 + frac * 125;
        if (us < 100000) us = 100000;
        return us / TICK_US;
    endfunction

    // driver: one access, expected response queued for the monitor
    task automatic access(input bit wr, input logic [ADDR_W-1:0] off,
                          input logic [31:0] wd, input logic [31:0] smp,
                          input logic [1:0] ecode, input logic [31:0] edata,
                          input string tag);
        exp_t e;
        e.code = ecode; e.data = edata; e.tag = tag;
        exp_q.push_back(e);
        req_valid  = 1'b1;
        req_write  = wr;
        req_offset = off;
        req_wdata  = wd;
        cyc_sample = smp;
        @(negedge clk);
        req_valid  = 1'b0;
        req_write  = 1'b0;
    endtask

    // monitor: compares each response against the queue head
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " code"}, rsp_code, e.code);
                check({e.tag, " data"}, rsp_rdata, e.data);
            end
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_to(input bit frac_reg, input logic [31:0] wd);
        if (frac_reg) begin
            m_frac = longint'(wd[31:19]);
            access(1'b1, 8'h04, wd, 32'd0, 2'd0, 32'd0, "R4 frac write");
        end else begin
            m_sec = longint'(wd[2:0]);
            access(1'b1, 8'h00, wd, 32'd0, 2'd0, 32'd0, "R4 sec write");
        end
    endtask

    initial begin
        wait_cycles(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 expiry after reset", expiry_ticks, 100);
        check("R1 no load after reset", cyc_load_valid, 0);
        access(1'b0, 8'h00, 0, 0, 2'd0, 32'd0, "R1 sec reset");
        access(1'b0, 8'h04, 0, 0, 2'd0, 32'h1900_0000, "R1 frac reset");

        // R5 / R6 no rollover
        access(1'b0, 8'h08, 0, 32'h0000_1000, 2'd0, 32'h0000_1000, "R5 cycle read");
        access(1'b0, 8'h0C, 0, 32'h0200_0000, 2'd0, 32'h0000_0001, "R6 bus read");
        // R5 rollover (0x100 < 0x02000000)
        access(1'b0, 8'h08, 0, 32'h0000_0100, 2'd0, 32'h0000_0100, "R5 rollover read");
        access(1'b0, 8'h0C, 0, 32'h0000_0300, 2'd0, 32'h0000_0080, "R5 seconds advanced");

        // R7 bus write masks low bits
        access(1'b1, 8'h0C, 32'hFFFF_FFFF, 0, 2'd0, 32'd0, "R7 bus write");
        access(1'b0, 8'h0C, 0, 32'hFE00_0000, 2'd0, 32'hFFFF_FFFF, "R7 bus readback");
        // R6 rollover found by a bus read, seconds wrap to zero in the same access
        access(1'b0, 8'h0C, 0, 32'h0400_0000, 2'd0, 32'h0000_0002, "R6 rollover on bus read");

        // R8 cycle write
        access(1'b1, 8'h08, 32'hABCD_0000, 0, 2'd0, 32'd0, "R8 cycle write");
        check("R8 load valid", cyc_load_valid, 1);
        check("R8 load data", cyc_load_data, 32'hABCD_0000);
        @(negedge clk);
        check("R8 load one cycle", cyc_load_valid, 0);
        access(1'b0, 8'h08, 0, 32'h5000_0000, 2'd0, 32'h5000_0000, "R8 compare base read");
        access(1'b0, 8'h0C, 0, 32'h5000_0000, 2'd0, 32'h0000_00A8, "R8 rollover vs written value");

        // R3 error handling
        access(1'b1, 8'h05, 32'h0, 0, 2'd1, 32'd0, "R3 misaligned write");
        access(1'b0, 8'h02, 32'h0, 0, 2'd1, 32'd0, "R3 misaligned read");
        access(1'b0, 8'h04, 0, 0, 2'd0, 32'h1900_0000, "R3 frac unchanged");
        access(1'b0, 8'h10, 0, 0, 2'd2, 32'd0, "R3 unmapped read");
        access(1'b1, 8'hFC, 32'hFFFF_FFFF, 0, 2'd2, 32'd0, "R3 unmapped write");
        access(1'b0, 8'h0C, 0, 32'h5000_0000, 2'd0, 32'h0000_00A8, "R3 bus unchanged");
        wait_cycles(40);
        check("R3 expiry unchanged", expiry_ticks, 100);

        // R4 masks and R9 conversion
        write_to(1'b0, 32'hFFFF_FFF9);
        write_to(1'b1, 32'hFFFF_FFFF);
        access(1'b0, 8'h00, 0, 0, 2'd0, 32'h0000_0001, "R4 sec readback");
        access(1'b0, 8'h04, 0, 0, 2'd0, 32'hFFF8_0000, "R4 frac readback");
        wait_cycles(30);
        check("R9 expiry large", expiry_ticks, model_ticks(m_sec, m_frac));

        write_to(1'b0, 32'h0);
        write_to(1'b1, 32'd8 << 19);
        wait_cycles(30);
        check("R9 expiry floor", expiry_ticks, model_ticks(m_sec, m_frac));

        write_to(1'b1, 32'd1601 << 19);
        wait_cycles(30);
        check("R9 expiry rounding", expiry_ticks, model_ticks(m_sec, m_frac));

        // R10 writes landing around the end of a running conversion
        for (int gap = 20; gap < 30; gap++) begin
            write_to(1'b1, (32'd3000 + 32'(gap)) << 19);
            wait_cycles(gap);
        end
        write_to(1'b0, 32'h5);
        wait_cycles(3);
        write_to(1'b1, 32'd77 << 19);
        wait_cycles(30);
        check("R10 last write wins", expiry_ticks, model_ticks(m_sec, m_frac));

        wait_cycles(4);
        check("R2 all responses seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule